// File: doc/BRIEF.md
# Dual-Channel Serial Converter Capture Controller

This block is the bus master for a two-channel serial analog-to-digital converter that sits on a shared serial bus. On a fixed schedule it asks an external arbiter for the bus. Once the arbiter grants it, the block raises a convert strobe for one serial-clock period, and the converter samples both inputs at that same moment. The block then clocks in 32 bits. Each 16-bit field holds two padding bits followed by a signed 14-bit result. The block then releases the bus so that other devices can use the clock and data lines.

The converter is pipelined. The words that come out during a frame belong to the conversion started by the previous strobe. For that reason the block never reports the first frame after reset, because it carries no real sample. Every later frame updates both parallel words together and raises a one-cycle valid pulse.

The serial clock is the system clock divided by `2*CLK_DIV`. The minimum spacing between convert strobes is `FRAME_CYCLES` system cycles. It must be at least `66*CLK_DIV+2` so that a frame fits, and it must be large enough to keep the strobe rate at or below about 1.5 MHz.

Top module: `adc_pair_capture`

## Requirements
- R1: While reset is asserted, busReq, busOwn, sclk, convert and dataValid are low, and chA and chB are zero.
- R2: The block raises busReq and holds it high until it is granted. While busGrant is low, convert stays low and the block does not take the bus.
- R3: Convert rises only while busGrant is high. It stays high for exactly 2*CLK_DIV system cycles, which is one serial-clock period.
- R4: Each sclk high phase lasts CLK_DIV cycles. A frame carries 33 sclk pulses: one during convert and 32 data pulses.
- R5: Two convert rising edges are never closer than FRAME_CYCLES system cycles.
- R6: miso is sampled on the last system cycle of each data high phase, most significant bit first. Bit k (counted from 0) of the frame goes as follows: bits 0-1 are ignored, bits 2-15 are chA, bits 16-17 are ignored, and bits 18-31 are chB.
- R7: The two's complement words reported after a frame are the values the converter shifted out during that frame. These are the samples of the convert strobe before that frame's strobe.
- R8: The first frame after reset raises no valid pulse and leaves chA and chB at zero.
- R9: dataValid is a one-cycle pulse in the cycle after busOwn falls. chA and chB change only in that cycle.
- R10: busOwn and busReq fall together at the end of the frame, and sclk is low whenever busOwn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busGrant | input | 1 | Arbiter grant of the shared bus |
| miso | input | 1 | Serial data from the converter |
| busReq | output | 1 | Request for the shared bus |
| busOwn | output | 1 | Block is driving the bus; usable as the output enable for sclk |
| sclk | output | 1 | Serial clock |
| convert | output | 1 | Convert strobe, active high |
| chA | output | DATA_W | Channel 0 result, signed |
| chB | output | DATA_W | Channel 1 result, signed |
| dataValid | output | 1 | One-cycle pulse marking new chA/chB |

## Verification
The grant assertion assumes that the arbiter keeps busGrant high from the grant until busReq drops. It also assumes that the converter holds miso steady through each high phase of sclk. The bench arbiter latches its grant for as long as the request stays up, and it only withholds the grant before a frame starts. The bench converter model changes miso only when it sees a rising sclk edge. The bench also assumes that FRAME_CYCLES is large enough for a whole frame, and the parameters it uses meet that bound.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CONV,
    ST_SHIFT,
    ST_DONE
  } ctrlState_e;

  typedef struct packed {
    logic shiftEn;
    logic commit;
  } dpStrobes_t;

endpackage

// File: rtl/adc_pair_ctrl.sv
module adc_pair_ctrl
  import adc_pair_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int FRAME_CYCLES = 300,
  parameter int DATA_W       = 14,
  parameter int PAD_BITS     = 2,
  parameter int NUM_CH       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  output logic       busReq,
  output logic       busOwn,
  output logic       sclk,
  output logic       convert,
  output dpStrobes_t strobes
);

  localparam int FIELD_W    = PAD_BITS + DATA_W;
  localparam int FRAME_BITS = NUM_CH * FIELD_W;
  localparam int PER_W      = $clog2(FRAME_BITS + 1);
  localparam int DIV_W      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_W      = $clog2(FRAME_CYCLES + 1);
  localparam int HIGH_W     = $clog2(2 * CLK_DIV + 1);

  ctrlState_e       state;
  logic [DIV_W-1:0] halfCnt;
  logic             phase;
  logic [PER_W-1:0] period;
  logic [GAP_W-1:0] gapCnt;
  logic             halfEnd;

  assign halfEnd = (halfCnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      phase   <= 1'b0;
      period  <= '0;
      gapCnt  <= '0;
    end else begin
      if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      case (state)
        ST_IDLE: if (gapCnt == '0) state <= ST_REQ;
        ST_REQ: begin
          if (busGrant) begin
            state   <= ST_CONV;
            phase   <= 1'b1;
            halfCnt <= '0;
            period  <= '0;
            gapCnt  <= GAP_W'(FRAME_CYCLES - 1);
          end
        end
        ST_CONV, ST_SHIFT: begin
          if (halfEnd) begin
            halfCnt <= '0;
            phase   <= ~phase;
            if (!phase) begin
              period <= period + 1'b1;
              if (state == ST_CONV) state <= ST_SHIFT;
              else if (period == PER_W'(FRAME_BITS)) state <= ST_DONE;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busOwn          = (state == ST_CONV) || (state == ST_SHIFT);
  assign busReq          = busOwn || (state == ST_REQ);
  assign convert         = (state == ST_CONV);
  assign sclk            = busOwn && phase;
  assign strobes.shiftEn = (state == ST_SHIFT) && phase && halfEnd;
  assign strobes.commit  = (state == ST_DONE);

  // Checking counters: cycles since the last strobe rise, length of strobe.
  logic [GAP_W-1:0]  sinceConv;
  logic              seenConv;
  logic              convD;
  logic [HIGH_W-1:0] convHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceConv <= '0;
      seenConv  <= 1'b0;
      convD     <= 1'b0;
      convHigh  <= '0;
    end else begin
      convD    <= convert;
      convHigh <= convert ? convHigh + 1'b1 : '0;
      if (convert && !convD) begin
        sinceConv <= GAP_W'(1);
        seenConv  <= 1'b1;
      end else if (sinceConv != GAP_W'(FRAME_CYCLES)) begin
        sinceConv <= sinceConv + 1'b1;
      end
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busOwn && !busGrant |=> busReq && !convert);

  p_conv_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convert) |-> busGrant);

  p_conv_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convert) |-> convHigh == HIGH_W'(2 * CLK_DIV));

  p_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convert) && seenConv |-> sinceConv >= GAP_W'(FRAME_CYCLES));

  p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOwn) |-> !busReq && !sclk);

endmodule

// File: rtl/adc_pair_datapath.sv
module adc_pair_datapath
  import adc_pair_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int PAD_BITS = 2,
  parameter int NUM_CH   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     miso,
  input  dpStrobes_t               strobes,
  output logic signed [DATA_W-1:0] chA,
  output logic signed [DATA_W-1:0] chB,
  output logic                     dataValid
);

  localparam int FIELD_W    = PAD_BITS + DATA_W;
  localparam int FRAME_BITS = NUM_CH * FIELD_W;
  localparam int PER_W      = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0]           shiftReg;
  logic [NUM_CH-1:0][DATA_W-1:0]   chWord;
  logic                            firstFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_BITS-2:0], miso};
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int TOP = FRAME_BITS - c * FIELD_W - PAD_BITS - 1;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chWord[c] <= '0;
      else if (strobes.commit && !firstFrame) chWord[c] <= shiftReg[TOP -: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstFrame <= 1'b1;
      dataValid  <= 1'b0;
    end else begin
      dataValid <= strobes.commit && !firstFrame;
      if (strobes.commit) firstFrame <= 1'b0;
    end
  end

  assign chA = chWord[0];
  assign chB = chWord[1];

  // Checking counters: shifts per frame and frames committed since reset.
  logic [PER_W-1:0] shiftCnt;
  logic [1:0]       commitsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCnt    <= '0;
      commitsSeen <= '0;
    end else begin
      if (strobes.commit) shiftCnt <= '0;
      else if (strobes.shiftEn) shiftCnt <= shiftCnt + 1'b1;
      if (strobes.commit && commitsSeen != 2'd2) commitsSeen <= commitsSeen + 1'b1;
    end
  end

  p_shift_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> shiftCnt == PER_W'(FRAME_BITS));

  p_first_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> commitsSeen == 2'd2);

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  p_hold_words_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable(chA) && $stable(chB));

endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
  import adc_pair_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int FRAME_CYCLES = 300,
  parameter int DATA_W       = 14,
  parameter int PAD_BITS     = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busGrant,
  input  logic                     miso,
  output logic                     busReq,
  output logic                     busOwn,
  output logic                     sclk,
  output logic                     convert,
  output logic signed [DATA_W-1:0] chA,
  output logic signed [DATA_W-1:0] chB,
  output logic                     dataValid
);

  localparam int NUM_CH = 2;

  dpStrobes_t strobes;

  adc_pair_ctrl #(
    .CLK_DIV(CLK_DIV), .FRAME_CYCLES(FRAME_CYCLES),
    .DATA_W(DATA_W), .PAD_BITS(PAD_BITS), .NUM_CH(NUM_CH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busGrant(busGrant),
    .busReq(busReq), .busOwn(busOwn), .sclk(sclk),
    .convert(convert), .strobes(strobes)
  );

  adc_pair_datapath #(
    .DATA_W(DATA_W), .PAD_BITS(PAD_BITS), .NUM_CH(NUM_CH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .miso(miso), .strobes(strobes),
    .chA(chA), .chB(chB), .dataValid(dataValid)
  );

endmodule

// File: tb/adc_pair_capture_test.sv
module adc_pair_capture_test;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_DIV      = 2;
  localparam int FRAME_CYCLES = 150;
  localparam int DW           = 14;
  localparam int FRAMES       = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGrant = 1'b0;
  logic miso = 1'b0;
  logic busReq, busOwn, sclk, convert, dataValid;
  logic signed [DW-1:0] chA, chB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_pair_capture #(.CLK_DIV(CLK_DIV), .FRAME_CYCLES(FRAME_CYCLES),
                     .DATA_W(DW), .PAD_BITS(2)) uut (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .miso(miso),
    .busReq(busReq), .busOwn(busOwn), .sclk(sclk), .convert(convert),
    .chA(chA), .chB(chB), .dataValid(dataValid));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic signed [DW-1:0] sampleA(input int n);
    case (n % 8)
      0: return 14'sd8191;
      1: return -14'sd8192;
      2: return -14'sd1;
      3: return 14'sd1;
      4: return 14'sd5461;
      5: return -14'sd5462;
      6: return 14'sd0;
      default: return 14'sd4096;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] sampleB(input int n);
    return sampleA(n + 3) ^ 14'sh0F0F;
  endfunction

  // Behavioural model: converter, arbiter and expected outputs.
  logic signed [DW-1:0] heldA = 14'sh1ABC, heldB = 14'sh2345;
  logic signed [DW-1:0] frameExpA = '0, frameExpB = '0;
  logic signed [DW-1:0] lastA = '0, lastB = '0;
  logic [31:0] frameBits = '0;
  int  convIdx = 0, bitPtr = 0, framesDone = 0, validCount = 0;
  int  cycle = 0, lastConv = -1, highRun = 0, convRun = 0, pulses = 0;
  bit  prevSclk = 0, prevConv = 0, prevOwn = 0, pendValid = 0, expValid = 0;
  bit  holdOff = 0;

  always @(negedge clk) begin
    if (rstN) begin
      cycle++;
      expValid = pendValid;
      pendValid = 0;
      chk(dataValid == expValid, "R9 valid timing", int'(dataValid), int'(expValid));
      if (expValid) begin
        chk(chA == frameExpA, "R7 chA word", int'(chA), int'(frameExpA));
        chk(chB == frameExpB, "R7 chB word", int'(chB), int'(frameExpB));
        lastA = frameExpA;
        lastB = frameExpB;
        validCount++;
      end else begin
        if (chA != lastA || chB != lastB)
          chk(0, "R9 words held", int'(chA), int'(lastA));
      end
      if (sclk && !busOwn) chk(0, "R10 sclk idle low", 1, 0);
      if (busOwn && !busReq) chk(0, "R10 request kept while owning", 0, 1);
      if (convert && !busGrant) chk(0, "R3 convert without grant", 1, 0);
      if (convert && holdOff && !prevConv) chk(0, "R2 convert during hold", 1, 0);
      // convert strobe rise: converter model shifts out previous sample
      if (convert && !prevConv) begin
        if (lastConv >= 0)
          chk(cycle - lastConv >= FRAME_CYCLES, "R5 strobe spacing", cycle - lastConv, FRAME_CYCLES);
        lastConv = cycle;
        frameBits = {2'b10, heldA, 2'b01, heldB};
        frameExpA = heldA;
        frameExpB = heldB;
        heldA = sampleA(convIdx);
        heldB = sampleB(convIdx);
        convIdx++;
        bitPtr = 0;
        pulses = 0;
      end
      if (convert) convRun++;
      if (!convert && prevConv) begin
        chk(convRun == 2 * CLK_DIV, "R3 strobe width", convRun, 2 * CLK_DIV);
        convRun = 0;
      end
      if (sclk) highRun++;
      if (sclk && !prevSclk) begin
        pulses++;
        if (!convert && busOwn && bitPtr < 32) begin
          miso = frameBits[31 - bitPtr];
          bitPtr++;
        end
      end
      if (!sclk && prevSclk) begin
        chk(highRun == CLK_DIV, "R4 sclk high phase", highRun, CLK_DIV);
        highRun = 0;
      end
      if (prevOwn && !busOwn) begin
        chk(pulses == 33, "R4 pulses per frame", pulses, 33);
        chk(!busReq, "R10 request released", int'(busReq), 0);
        pendValid = (framesDone > 0);
        framesDone++;
      end
      prevSclk = sclk;
      prevConv = convert;
      prevOwn  = busOwn;
      if (busGrant && busReq) busGrant = 1'b1;
      else busGrant = busReq && !holdOff;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busReq && !busOwn && !sclk && !convert, "R1 reset bus", int'({busReq, busOwn, sclk, convert}), 0);
    chk(!dataValid && chA == 0 && chB == 0, "R1 reset outputs", int'(chA), 0);
    @(negedge clk);
    rstN = 1'b1;
    wait (framesDone == 1);
    repeat (4) @(negedge clk);
    chk(validCount == 0, "R8 no valid for first frame", validCount, 0);
    chk(chA == 0 && chB == 0, "R8 words untouched", int'(chA), 0);
    wait (framesDone == 3);
    holdOff = 1;
    repeat (300) @(negedge clk);
    chk(busReq == 1'b1, "R2 request held while refused", int'(busReq), 1);
    chk(!busOwn && !convert, "R2 no bus without grant", int'(busOwn), 0);
    holdOff = 0;
    wait (framesDone == FRAMES);
    repeat (4) @(negedge clk);
    chk(validCount == FRAMES - 1, "R7 frame count reported", validCount, FRAMES - 1);
    chk(convIdx == FRAMES, "R5 strobes issued", convIdx, FRAMES);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", framesDone, FRAMES);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule